// File: doc/BRIEF.md
# Multi-Cycle Multiply-Accumulate Unit

This block multiplies two operands and either writes the product or adds it into a 64-bit accumulator. The accumulator is read as a high half and a low half of 32 bits each. There are four operations. Two use the low 16 bits of each operand and two use the full 32 bits. Each width has a plain multiply and a multiply-add form. A single signed/unsigned select applies to all four.

A request is made by raising `start` for one cycle with the operation, the sign select and both operands. The operands are captured on that edge. The unit sequences its work over a fixed number of cycles per operation and raises `done` for one cycle on the edge that writes the accumulator. `busy` covers the cycles in between.

The datapath has one 17 x 33 signed row multiplier. A 16-bit operation uses it once. A 32-bit operation uses it twice, first on the low half of operand A and then on the high half, and the two rows are summed. A clear command zeroes the accumulator when the unit is idle.

Top module: `mac_unit`

## Requirements
- R1: With `op` = 0 (16x16 multiply), the 32-bit product of `opa[15:0]` and `opb[15:0]` is written to `acc_lo`, `acc_hi` keeps its value, and `done` is high in the cycle after the start edge (latency 1).
- R2: With `op` = 1 (16x16 multiply-add), the 16x16 product is extended to 64 bits and added into {`acc_hi`,`acc_lo`} modulo 2^64. Latency is 2.
- R3: With `op` = 2 (32x32 multiply), the full 64-bit product replaces {`acc_hi`,`acc_lo`}. Latency is 2.
- R4: With `op` = 3 (32x32 multiply-add), the 64-bit product is added into {`acc_hi`,`acc_lo`} modulo 2^64. Latency is 3.
- R5: `is_signed` = 1 treats both operands as two's complement (sign extension). `is_signed` = 0 treats them as unsigned (zero extension).
- R6: Operands, operation and sign select are taken only on the accepting edge. Changes to them afterwards do not affect the result.
- R7: When the unit is idle and `start` is low, `clear` zeroes both accumulator halves on the next edge. If `start` is high in the same cycle, the start is taken and the clear is dropped.
- R8: `clear` while `busy` is high is ignored.
- R9: `start` while `busy` is high is ignored and does not queue an operation.
- R10: `done` is high for exactly one cycle per accepted operation, in the cycle the result first appears. `busy` is high from the accepting edge until that cycle and is low while `done` is high.
- R11: After reset, both accumulator halves are zero and `busy` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request an operation (taken when not busy) |
| op | input | 2 | 0 mul16, 1 mac16, 2 mul32, 3 mac32 |
| is_signed | input | 1 | 1 = two's complement operands |
| clear | input | 1 | Zero the accumulator when idle |
| opa | input | 32 | Operand A |
| opb | input | 32 | Operand B |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse when the result is written |
| acc_hi | output | 32 | Accumulator bits 63..32 |
| acc_lo | output | 32 | Accumulator bits 31..0 |

## Verification
The bench builds the unit with its default half width of 16, which gives 32-bit operands and a 64-bit accumulator. Its reference model can then form every expected value as a plain 64-bit modular product and sum. At this width the row split falls exactly at bit 16. This brings within reach the carries and borrows that cross the boundary between the two rows. It also covers the most negative signed operands and all-ones unsigned operands, where a sign-extension fault in either row changes the upper accumulator half.

// File: rtl/mac_pkg.sv
package mac_pkg;

    typedef enum logic [1:0] {
        OP_MUL16 = 2'd0,
        OP_MAC16 = 2'd1,
        OP_MUL32 = 2'd2,
        OP_MAC32 = 2'd3
    } mac_op_e;

    // Sequencer state: one bit each for busy and done, the step counter and the held operation.
    typedef struct packed {
        logic    busy;
        logic    done;
        logic [1:0] step;
        mac_op_e op;
    } seq_state_t;

    // Fixed cycle count from the accepting edge to the writing edge, inclusive.
    function automatic logic [1:0] op_latency(mac_op_e op);
        case (op)
            OP_MUL16: op_latency = 2'd1;
            OP_MAC16: op_latency = 2'd2;
            OP_MUL32: op_latency = 2'd2;
            default:  op_latency = 2'd3;
        endcase
    endfunction

endpackage

// File: rtl/mac_row_mult.sv
module mac_row_mult #(
    parameter int XW = 17,
    parameter int YW = 33,
    localparam int PW = XW + YW
) (
    input  logic [XW-1:0] x_i,
    input  logic [YW-1:0] y_i,
    output logic [PW-1:0] p_o
);

    logic signed [PW-1:0] xs;
    logic signed [PW-1:0] ys;

    // Both factors arrive already extended by the caller. Widen them to the product width.
    assign xs = $signed({{(PW-XW){x_i[XW-1]}}, x_i});
    assign ys = $signed({{(PW-YW){y_i[YW-1]}}, y_i});
    assign p_o = xs * ys;

endmodule

// File: rtl/mac_seq.sv
module mac_seq
    import mac_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  mac_op_e    op_i,
    output logic       busy_o,
    output logic       done_o,
    output logic       accept_o,
    output logic       commit_o,
    output logic [1:0] phase_o,
    output mac_op_e    op_o
);

    seq_state_t s_d, s_q;
    logic [1:0] last_step;

    always_comb begin
        s_d       = s_q;
        s_d.done  = 1'b0;
        accept_o  = start_i && !s_q.busy;
        op_o      = accept_o ? op_i : s_q.op;
        phase_o   = accept_o ? 2'd0 : s_q.step;
        last_step = op_latency(op_o) - 2'd1;
        commit_o  = (accept_o || s_q.busy) && (phase_o == last_step);

        if (accept_o) begin
            s_d.op = op_i;
        end
        if (accept_o || s_q.busy) begin
            if (commit_o) begin
                s_d.busy = 1'b0;
                s_d.step = 2'd0;
                s_d.done = 1'b1;
            end else begin
                s_d.busy = 1'b1;
                s_d.step = phase_o + 2'd1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o = s_q.busy;
    assign done_o = s_q.done;

    // R10
    done_busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.done |-> !s_q.busy);

    // R10
    busy_ends_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.busy |=> (s_q.busy || s_q.done));

    // R9
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.busy) |-> $past(start_i));

    // R9
    busy_op_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && start_i) |=> $stable(s_q.op));

    // R4
    step_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.busy |-> (s_q.step < op_latency(s_q.op)));

endmodule

// File: rtl/mac_datapath.sv
module mac_datapath
    import mac_pkg::*;
#(
    parameter int HALF_W = 16,
    localparam int OPW  = 2 * HALF_W,
    localparam int ACCW = 2 * OPW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            accept_i,
    input  logic            busy_i,
    input  logic            commit_i,
    input  logic            clear_i,
    input  logic            sgn_i,
    input  mac_op_e         op_i,
    input  logic [1:0]      phase_i,
    input  logic [OPW-1:0]  a_i,
    input  logic [OPW-1:0]  b_i,
    output logic [ACCW-1:0] acc_o
);

    localparam int XW = HALF_W + 1;
    localparam int YW = OPW + 1;
    localparam int PW = XW + YW;

    typedef struct packed {
        logic [OPW-1:0]  a;
        logic [OPW-1:0]  b;
        logic            sgn;
        logic [ACCW-1:0] part;
        logic [ACCW-1:0] acc;
    } dp_state_t;

    dp_state_t d, q;

    logic [OPW-1:0]  a_src, b_src;
    logic            sgn_src;
    logic            is16;
    logic [XW-1:0]   x_sel;
    logic [YW-1:0]   y_sel;
    logic [PW-1:0]   row;
    logic [ACCW-1:0] row_ext;
    logic [ACCW-1:0] row_sh;

    // Operands come from the ports on the accepting edge and from the held copy after it.
    assign a_src   = accept_i ? a_i   : q.a;
    assign b_src   = accept_i ? b_i   : q.b;
    assign sgn_src = accept_i ? sgn_i : q.sgn;
    assign is16    = (op_i == OP_MUL16) || (op_i == OP_MAC16);

    always_comb begin
        if (is16) begin
            x_sel = {sgn_src & a_src[HALF_W-1], a_src[HALF_W-1:0]};
            y_sel = {{(YW-HALF_W){sgn_src & b_src[HALF_W-1]}}, b_src[HALF_W-1:0]};
        end else begin
            // First row: low half of A, always unsigned. Second row: high half of A, carrying the sign.
            if (phase_i == 2'd0) begin
                x_sel = {1'b0, a_src[HALF_W-1:0]};
            end else begin
                x_sel = {sgn_src & a_src[OPW-1], a_src[OPW-1:HALF_W]};
            end
            y_sel = {sgn_src & b_src[OPW-1], b_src};
        end
    end

    mac_row_mult #(.XW(XW), .YW(YW)) i_row (
        .x_i (x_sel),
        .y_i (y_sel),
        .p_o (row)
    );

    generate
        if (PW < ACCW) begin : g_row_widen
            assign row_ext = {{(ACCW-PW){row[PW-1]}}, row};
        end else begin : g_row_trim
            assign row_ext = row[ACCW-1:0];
        end
    endgenerate

    assign row_sh = row_ext << HALF_W;

    always_comb begin
        d = q;
        if (accept_i) begin
            d.a   = a_i;
            d.b   = b_i;
            d.sgn = sgn_i;
        end
        if (accept_i || busy_i) begin
            case (op_i)
                OP_MUL16: begin
                    d.acc[OPW-1:0] = row_ext[OPW-1:0];
                end
                OP_MAC16: begin
                    if (phase_i == 2'd0) d.part = row_ext;
                    else                 d.acc  = q.acc + q.part;
                end
                OP_MUL32: begin
                    if (phase_i == 2'd0) d.part = row_ext;
                    else                 d.acc  = q.part + row_sh;
                end
                default: begin
                    if (phase_i == 2'd0)      d.part = row_ext;
                    else if (phase_i == 2'd1) d.part = q.part + row_sh;
                    else                      d.acc  = q.acc + q.part;
                end
            endcase
        end else if (clear_i) begin
            d.acc = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign acc_o = q.acc;

    // R8
    acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((accept_i || busy_i) && !commit_i) |=> $stable(q.acc));

    // R7
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_i && !busy_i && !accept_i) |=> (q.acc == '0));

    // R1
    mul16_hi_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_i && op_i == OP_MUL16) |=> $stable(q.acc[ACCW-1:OPW]));

    // R6
    operand_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && !accept_i) |=> ($stable(q.a) && $stable(q.b)));

endmodule

// File: rtl/mac_unit.sv
module mac_unit
    import mac_pkg::*;
#(
    parameter int HALF_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [1:0]          op,
    input  logic                is_signed,
    input  logic                clear,
    input  logic [2*HALF_W-1:0] opa,
    input  logic [2*HALF_W-1:0] opb,
    output logic                busy,
    output logic                done,
    output logic [2*HALF_W-1:0] acc_hi,
    output logic [2*HALF_W-1:0] acc_lo
);

    localparam int OPW  = 2 * HALF_W;
    localparam int ACCW = 2 * OPW;

    logic            accept, commit;
    logic [1:0]      phase;
    mac_op_e         cur_op;
    logic [ACCW-1:0] acc;

    mac_seq i_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start),
        .op_i     (mac_op_e'(op)),
        .busy_o   (busy),
        .done_o   (done),
        .accept_o (accept),
        .commit_o (commit),
        .phase_o  (phase),
        .op_o     (cur_op)
    );

    mac_datapath #(.HALF_W(HALF_W)) i_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept_i (accept),
        .busy_i   (busy),
        .commit_i (commit),
        .clear_i  (clear),
        .sgn_i    (is_signed),
        .op_i     (cur_op),
        .phase_i  (phase),
        .a_i      (opa),
        .b_i      (opb),
        .acc_o    (acc)
    );

    assign acc_hi = acc[ACCW-1:OPW];
    assign acc_lo = acc[OPW-1:0];

endmodule

// File: tb/test_mac_unit.sv
module test_mac_unit;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start, is_signed, clear;
    logic [1:0]  op;
    logic [31:0] opa, opb;
    logic        busy, done;
    logic [31:0] acc_hi, acc_lo;

    int errs   = 0;
    int checks = 0;
    logic [63:0] model = '0;

    always #4 clk = ~clk;

    mac_unit i_mac_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .is_signed(is_signed),
        .clear(clear), .opa(opa), .opb(opb), .busy(busy), .done(done),
        .acc_hi(acc_hi), .acc_lo(acc_lo)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] ref_prod(input logic [1:0] o, input logic s,
                                             input logic [31:0] a, input logic [31:0] b);
        logic [63:0] ea, eb;
        if (o < 2'd2) begin
            ea = s ? {{48{a[15]}}, a[15:0]} : {48'b0, a[15:0]};
            eb = s ? {{48{b[15]}}, b[15:0]} : {48'b0, b[15:0]};
        end else begin
            ea = s ? {{32{a[31]}}, a} : {32'b0, a};
            eb = s ? {{32{b[31]}}, b} : {32'b0, b};
        end
        return ea * eb;
    endfunction

    function automatic logic [63:0] ref_apply(input logic [1:0] o, input logic [63:0] acc,
                                              input logic [63:0] p);
        case (o)
            2'd0:    return {acc[63:32], p[31:0]};
            2'd2:    return p;
            default: return acc + p;
        endcase
    endfunction

    function automatic int lat_of(input logic [1:0] o);
        case (o)
            2'd0:    return 1;
            2'd3:    return 3;
            default: return 2;
        endcase
    endfunction

    // Runs one operation, scrambles operands after acceptance (R6), checks latency, busy, result, pulse.
    task automatic run_op(input string req, input logic [1:0] o, input logic s,
                          input logic [31:0] a, input logic [31:0] b);
        int n;
        @(negedge clk);
        op = o; is_signed = s; opa = a; opb = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0; opa = ~a ^ 32'h5A5A_1234; opb = a + 32'h0F0F_0F0F;
        op = ~o; is_signed = ~s;
        n = 1;
        while (!done && n < 8) begin
            chk({req, " R10 busy during op"}, 64'(busy), 64'd1);
            @(negedge clk);
            n++;
        end
        chk({req, " latency"}, 64'(n), 64'(lat_of(o)));
        chk({req, " R10 busy low at done"}, 64'(busy), 64'd0);
        model = ref_apply(o, model, ref_prod(o, s, a, b));
        chk({req, " R6 R5 result"}, {acc_hi, acc_lo}, model);
        @(negedge clk);
        chk({req, " R10 single pulse"}, 64'(done), 64'd0);
    endtask

    task automatic t_reset();
        chk("R11 acc", {acc_hi, acc_lo}, 64'd0);
        chk("R11 busy", 64'(busy), 64'd0);
        chk("R11 done", 64'(done), 64'd0);
    endtask

    task automatic t_mul16();
        model = 64'hDEAD_BEEF_0000_0000;
        run_op("R3 preload", 2'd2, 1'b0, 32'hDEAD_BEEF, 32'h1_0000);
        model = 64'hDEAD_BEEF_0000_0000;
        chk("R3 preload value", {acc_hi, acc_lo}, 64'h0000_DEAD_BEEF_0000);
        model = {acc_hi, acc_lo};
        run_op("R1 unsigned", 2'd0, 1'b0, 32'hAAAA_FFFF, 32'h5555_FFFF);
        run_op("R1 R5 signed", 2'd0, 1'b1, 32'h0000_8000, 32'h0000_7FFF);
        run_op("R1 R5 neg*neg", 2'd0, 1'b1, 32'h1234_8000, 32'h0000_8000);
    endtask

    task automatic t_mac16();
        run_op("R2 unsigned", 2'd1, 1'b0, 32'h0000_FFFF, 32'h0000_FFFF);
        run_op("R2 R5 signed neg", 2'd1, 1'b1, 32'h0000_FFFF, 32'h0000_0003);
        run_op("R2 R5 signed big", 2'd1, 1'b1, 32'h0000_8001, 32'h0000_7FFF);
    endtask

    task automatic t_mul32();
        run_op("R3 unsigned max", 2'd2, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        run_op("R3 R5 signed min", 2'd2, 1'b1, 32'h8000_0000, 32'h8000_0000);
        run_op("R3 R5 signed mixed", 2'd2, 1'b1, 32'hFFFF_0001, 32'h7654_3210);
    endtask

    task automatic t_mac32();
        run_op("R4 unsigned", 2'd3, 1'b0, 32'h1234_5678, 32'h9ABC_DEF0);
        run_op("R4 R5 signed", 2'd3, 1'b1, 32'hFFFF_FFFF, 32'h0000_0005);
        run_op("R4 R5 signed wrap", 2'd3, 1'b1, 32'h8000_0000, 32'h7FFF_FFFF);
    endtask

    task automatic t_clear_idle();
        @(negedge clk);
        clear = 1'b1;
        @(negedge clk);
        clear = 1'b0;
        model = '0;
        chk("R7 clear one cycle", {acc_hi, acc_lo}, 64'd0);
    endtask

    task automatic t_clear_vs_start();
        logic [63:0] p;
        @(negedge clk);
        op = 2'd2; is_signed = 1'b0; opa = 32'h0000_0010; opb = 32'h0000_0020;
        start = 1'b1; clear = 1'b1;
        @(negedge clk);
        start = 1'b0; clear = 1'b0;
        chk("R7 start wins busy", 64'(busy), 64'd1);
        @(negedge clk);
        p = 64'h200;
        chk("R7 start wins done", 64'(done), 64'd1);
        chk("R7 start wins result", {acc_hi, acc_lo}, p);
        model = p;
    endtask

    task automatic t_clear_busy();
        @(negedge clk);
        op = 2'd3; is_signed = 1'b0; opa = 32'h0001_0003; opb = 32'h0002_0005; start = 1'b1;
        @(negedge clk);
        start = 1'b0; clear = 1'b1;
        @(negedge clk);
        chk("R8 acc kept mid-op", {acc_hi, acc_lo}, model);
        @(negedge clk);
        clear = 1'b0;
        model = model + ref_prod(2'd3, 1'b0, 32'h0001_0003, 32'h0002_0005);
        chk("R8 done", 64'(done), 64'd1);
        chk("R8 clear ignored", {acc_hi, acc_lo}, model);
    endtask

    task automatic t_start_busy();
        @(negedge clk);
        op = 2'd3; is_signed = 1'b1; opa = 32'hFFFF_FFFE; opb = 32'h0000_0100; start = 1'b1;
        @(negedge clk);
        op = 2'd2; opa = 32'h1111_1111; opb = 32'h2222_2222;
        @(negedge clk);
        chk("R9 still busy", 64'(busy), 64'd1);
        @(negedge clk);
        start = 1'b0;
        model = model + ref_prod(2'd3, 1'b1, 32'hFFFF_FFFE, 32'h0000_0100);
        chk("R9 done", 64'(done), 64'd1);
        chk("R9 result", {acc_hi, acc_lo}, model);
        @(negedge clk);
        chk("R9 no queued op busy", 64'(busy), 64'd0);
        chk("R9 no queued op done", 64'(done), 64'd0);
        chk("R9 acc unchanged", {acc_hi, acc_lo}, model);
    endtask

    initial begin
        #(8 * 100000);
        errs++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; start = 1'b0; clear = 1'b0; op = 2'd0; is_signed = 1'b0;
        opa = '0; opb = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mul16();
        t_mac16();
        t_mul32();
        t_mac32();
        t_clear_idle();
        t_clear_vs_start();
        t_clear_busy();
        t_start_busy();
        t_clear_idle();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule